// File: doc/BRIEF.md
# Set-Associative Page Translation Lookup

The block turns a 32-bit virtual address into a physical page address. It does this by searching a small set-associative translation buffer for the running process. Pages are 4 KB, so the virtual page number (VPN) is address bits [31:12]. The low VPN bits select one set. Every way of that set is compared in the same cycle. A way matches when its stored VPN equals the request VPN and, in addition, either the entry is marked global or its stored process identifier equals the current one. When more than one way matches, the lowest-numbered way wins. The registered response gives the following:
- a hit flag;
- the winning way;
- the physical page address;
- read, write and execute permission bits;
- an access-allowed flag for the requested access kind.

Software or a miss handler fills and inspects the storage through a management port. The management address is `way * SETS + set`. Each entry holds a tag word and a data word.

Tag layout:
- VPN in bits [31:12];
- global in bit 11;
- valid in bit 10;
- the process identifier in bits [PID_W-1:0].

Data layout:
- page frame number (PFN) in bits [PFN_W-1:0];
- execute at bit PFN_W;
- write at PFN_W+1;
- read at PFN_W+2;
- a cache flag at PFN_W+3.

The current process identifier is taken from bits [4 +: PID_W] of the last value written to the control word.

Top module: `tlb_lookup_unit`

## Requirements
- R1: A synchronous active-high reset clears rsp_valid, rsp_hit, rsp_allow, the response address, the permissions, the management read outputs and the current process identifier. A reset in the same cycle as a request wins over the request.
- R2: A request with req_valid=1 produces rsp_valid=1 one clock later. A non-global entry hits when its tag VPN (bits [31:12]) equals req_vaddr[31:12] and its tag bits [PID_W-1:0] equal the current process identifier. With no request, rsp_valid and rsp_hit are 0.
- R3: An entry with tag bit 11 (global) set hits for any current process identifier, provided the VPN matches.
- R4: A non-global entry whose stored process identifier differs from the current one in any of its PID_W bits does not hit. On a miss, rsp_paddr, rsp_rd, rsp_wr, rsp_ex and rsp_allow are all 0.
- R5: Tag bit 10 (valid) has no effect on matching. An entry with that bit clear still hits.
- R6: The set searched is VPN & (SETS-1), and the entry at management address a sits in way a/SETS at set a%SETS. An entry written into a different set than its VPN indexes is never found, and a management write is seen by lookups issued in later cycles.
- R7: When several ways match, rsp_way reports the lowest-numbered matching way, and the response comes from that way.
- R8: On a hit, rsp_paddr is the PFN shifted left by 12, with the low 12 bits zero. rsp_rd, rsp_wr and rsp_ex are data bits PFN_W+2, PFN_W+1 and PFN_W (bits 22, 21 and 20 by default).
- R9: req_kind encodes 0 read, 1 write, 2 fetch and 3 none. rsp_allow is 1 only on a hit whose permission bit for that kind (rd, wr or ex respectively) is set. It is always 0 for kind 3.
- R10: A control write loads the current process identifier from ctl_wr_data[4 +: PID_W]; all other bits of that word have no effect. A lookup in the same cycle as the control write still uses the previous identifier.
- R11: A management read (mgmt_en=1, mgmt_we=0) presents the addressed entry's tag on mgmt_rtag and its data on mgmt_rdata one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 none |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wr_data | input | 32 | Control word; the process identifier is in bits [4 +: PID_W] |
| mgmt_en | input | 1 | Management access strobe |
| mgmt_we | input | 1 | 1 = write the entry, 0 = read it |
| mgmt_addr | input | log2(ENTRIES) | Entry address: way * SETS + set |
| mgmt_wtag | input | 32 | Tag word to write |
| mgmt_wdata | input | PFN_W+4 | Data word to write |
| mgmt_rtag | output | 32 | Tag word read back |
| mgmt_rdata | output | PFN_W+4 | Data word read back |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_way | output | log2(WAYS) | Winning way |
| rsp_paddr | output | PFN_W+12 | Physical page address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_allow | output | 1 | Requested access kind permitted |

## Verification
Every lookup result, including the way, address, permissions and allow flag, is due on the first rising edge after the request cycle. Management read data is also due one edge after the read. A new process identifier applies to requests issued from the cycle after the control write. The bench drives inputs on the falling edge and samples each response on the falling edge immediately after the single registering edge. It also places a control write and a request in the same cycle, to show that the old identifier applies to that request and the new one to the next.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = 32 - PAGE_SHIFT;
  localparam int TAG_W      = 32;
  localparam int TAG_GLOBAL = 11;
  localparam int TAG_VALID  = 10;
  localparam int PID_SHIFT  = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int SETS  = 16,
  parameter int DAT_W = 24,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         mg_idx,
  input  logic [tlb_pkg::TAG_W-1:0] wr_tag,
  input  logic [DAT_W-1:0]         wr_dat,
  input  logic [IDX_W-1:0]         lk_idx,
  output logic [tlb_pkg::TAG_W-1:0] lk_tag,
  output logic [DAT_W-1:0]         lk_dat,
  output logic [tlb_pkg::TAG_W-1:0] mg_tag,
  output logic [DAT_W-1:0]         mg_dat
);
  logic [tlb_pkg::TAG_W-1:0] tag_mem [SETS];
  logic [DAT_W-1:0]          dat_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[mg_idx] <= wr_tag;
      dat_mem[mg_idx] <= wr_dat;
    end
  end

  // two asynchronous read ports: one for the lookup set, one for management
  assign lk_tag = tag_mem[lk_idx];
  assign lk_dat = dat_mem[lk_idx];
  assign mg_tag = tag_mem[mg_idx];
  assign mg_dat = dat_mem[mg_idx];
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int PID_W = 8
) (
  input  logic [tlb_pkg::TAG_W-1:0] tag,
  input  logic [tlb_pkg::VPN_W-1:0] vpn,
  input  logic [PID_W-1:0]          pid,
  output logic                      hit
);
  import tlb_pkg::*;

  logic vpn_eq, pid_eq, is_global;

  assign vpn_eq    = (tag[TAG_W-1:PAGE_SHIFT] == vpn);
  assign is_global = tag[TAG_GLOBAL];
  assign pid_eq    = (tag[PID_W-1:0] == pid);
  assign hit       = vpn_eq && (is_global || pid_eq);

  // the stored valid flag and the gap above the PID never take part in matching
  logic unused_tag_bits;
  assign unused_tag_bits = ^tag[TAG_GLOBAL-1:PID_W];
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  match,
  output logic             any,
  output logic [WAY_W-1:0] way,
  output logic [WAYS-1:0]  grant
);
  always_comb begin
    way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) way = i[WAY_W-1:0];
    end
    any   = |match;
    grant = any ? (WAYS'(1) << way) : '0;
  end

  // R7: the granted way is a single matching way with no lower match
  always_comb begin
    p_grant_lowest_r7: assert ($onehot0(grant) && ((grant & ~match) == '0)
                               && ((match & (grant - WAYS'(1))) == '0));
  end
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit #(
  parameter int WAYS    = 4,
  parameter int ENTRIES = 64,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [31:0]                  req_vaddr,
  input  logic [1:0]                   req_kind,
  input  logic                         ctl_wr_en,
  input  logic [31:0]                  ctl_wr_data,
  input  logic                         mgmt_en,
  input  logic                         mgmt_we,
  input  logic [$clog2(ENTRIES)-1:0]   mgmt_addr,
  input  logic [31:0]                  mgmt_wtag,
  input  logic [PFN_W+3:0]             mgmt_wdata,
  output logic [31:0]                  mgmt_rtag,
  output logic [PFN_W+3:0]             mgmt_rdata,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [$clog2(WAYS)-1:0]      rsp_way,
  output logic [PFN_W+11:0]            rsp_paddr,
  output logic                         rsp_rd,
  output logic                         rsp_wr,
  output logic                         rsp_ex,
  output logic                         rsp_allow
);
  import tlb_pkg::*;

  localparam int SETS   = ENTRIES / WAYS;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int ADDR_W = $clog2(ENTRIES);
  localparam int DAT_W  = PFN_W + 4;
  localparam int DAT_X  = PFN_W;
  localparam int DAT_WR = PFN_W + 1;
  localparam int DAT_RD = PFN_W + 2;
  localparam int DAT_C  = PFN_W + 3;

  // current process identifier
  logic [PID_W-1:0] cur_pid;
  always_ff @(posedge clk) begin
    if (rst)            cur_pid <= '0;
    else if (ctl_wr_en) cur_pid <= ctl_wr_data[PID_SHIFT +: PID_W];
  end

  // request decode
  logic [VPN_W-1:0] req_vpn;
  logic [IDX_W-1:0] lk_idx;
  logic [WAY_W-1:0] mg_way;
  logic [IDX_W-1:0] mg_idx;
  assign req_vpn = req_vaddr[31:PAGE_SHIFT];
  assign lk_idx  = req_vpn[IDX_W-1:0];
  assign mg_way  = mgmt_addr[ADDR_W-1 -: WAY_W];
  assign mg_idx  = mgmt_addr[IDX_W-1:0];

  logic [TAG_W-1:0] lk_tag [WAYS];
  logic [DAT_W-1:0] lk_dat [WAYS];
  logic [TAG_W-1:0] mg_tag [WAYS];
  logic [DAT_W-1:0] mg_dat [WAYS];
  logic [WAYS-1:0]  way_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic way_wr;
    assign way_wr = mgmt_en && mgmt_we && (mg_way == WAY_W'(w));

    tlb_way_store #(.SETS(SETS), .DAT_W(DAT_W)) u_store (
      .clk    (clk),
      .wr_en  (way_wr),
      .mg_idx (mg_idx),
      .wr_tag (mgmt_wtag),
      .wr_dat (mgmt_wdata),
      .lk_idx (lk_idx),
      .lk_tag (lk_tag[w]),
      .lk_dat (lk_dat[w]),
      .mg_tag (mg_tag[w]),
      .mg_dat (mg_dat[w])
    );

    tlb_match #(.PID_W(PID_W)) u_match (
      .tag (lk_tag[w]),
      .vpn (req_vpn),
      .pid (cur_pid),
      .hit (way_match[w])
    );
  end

  logic             any_match;
  logic [WAY_W-1:0] win_way;
  logic [WAYS-1:0]  win_grant;

  tlb_pick #(.WAYS(WAYS)) u_pick (
    .match (way_match),
    .any   (any_match),
    .way   (win_way),
    .grant (win_grant)
  );

  logic [DAT_W-1:0] win_dat;
  logic             nxt_hit, nxt_rd, nxt_wr, nxt_ex, nxt_allow;
  assign win_dat = lk_dat[win_way];

  always_comb begin
    nxt_hit = req_valid && any_match;
    nxt_rd  = nxt_hit && win_dat[DAT_RD];
    nxt_wr  = nxt_hit && win_dat[DAT_WR];
    nxt_ex  = nxt_hit && win_dat[DAT_X];
    unique case (acc_kind_t'(req_kind))
      ACC_READ:  nxt_allow = nxt_rd;
      ACC_WRITE: nxt_allow = nxt_wr;
      ACC_FETCH: nxt_allow = nxt_ex;
      default:   nxt_allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_paddr <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= nxt_hit;
      rsp_way   <= nxt_hit ? win_way : '0;
      rsp_paddr <= nxt_hit ? {win_dat[PFN_W-1:0], {PAGE_SHIFT{1'b0}}} : '0;
      rsp_rd    <= nxt_rd;
      rsp_wr    <= nxt_wr;
      rsp_ex    <= nxt_ex;
      rsp_allow <= nxt_allow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mgmt_rtag  <= '0;
      mgmt_rdata <= '0;
    end else if (mgmt_en && !mgmt_we) begin
      mgmt_rtag  <= mg_tag[mg_way];
      mgmt_rdata <= mg_dat[mg_way];
    end
  end

  logic unused_inputs;
  assign unused_inputs = ^{req_vaddr[PAGE_SHIFT-1:0], ctl_wr_data, win_dat[DAT_C], win_grant};

  // R2: a hit is only ever reported together with a response strobe
  p_hit_has_valid_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  // R4: a miss presents no address and no permission
  p_miss_clear_r4: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0 && !rsp_rd && !rsp_wr && !rsp_ex));

  // R9: access allowed implies a hit with at least one permission
  p_allow_needs_hit_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_allow |-> (rsp_hit && (rsp_rd || rsp_wr || rsp_ex)));

  // R10: the identifier changes only after a control write
  p_pid_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr_en |=> $stable(cur_pid));
endmodule

// File: tb/sim_tlb_lookup_unit.sv
module sim_tlb_lookup_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        mgmt_en = 1'b0;
  logic        mgmt_we = 1'b0;
  logic [5:0]  mgmt_addr = '0;
  logic [31:0] mgmt_wtag = '0;
  logic [23:0] mgmt_wdata = '0;
  logic [31:0] mgmt_rtag;
  logic [23:0] mgmt_rdata;
  logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_allow;
  logic [1:0]  rsp_way;
  logic [31:0] rsp_paddr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tlb_lookup_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .mgmt_en(mgmt_en), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
    .mgmt_wtag(mgmt_wtag), .mgmt_wdata(mgmt_wdata), .mgmt_rtag(mgmt_rtag),
    .mgmt_rdata(mgmt_rdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd),
    .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_allow(rsp_allow)
  );

  typedef struct packed {
    logic [31:0] vaddr;
    logic [1:0]  kind;
    logic [7:0]  pid;
    logic        hit;
    logic [1:0]  way;
    logic [31:0] paddr;
    logic [2:0]  perm;   // {rd, wr, ex}
    logic        allow;
    logic [31:0] req_tag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h00013ABC, 2'd0, 8'h05, 1'b1, 2'd0, 32'h0ABCD000, 3'b110, 1'b1, "R2"},
    '{32'h00013000, 2'd2, 8'h07, 1'b1, 2'd1, 32'h11111000, 3'b001, 1'b1, "R3"},
    '{32'h00013000, 2'd0, 8'h07, 1'b1, 2'd1, 32'h11111000, 3'b001, 1'b0, "R9"},
    '{32'h12347FFF, 2'd2, 8'h05, 1'b1, 2'd2, 32'h22222000, 3'b101, 1'b1, "R5"},
    '{32'h12347010, 2'd0, 8'h06, 1'b0, 2'd0, 32'h00000000, 3'b000, 1'b0, "R4"},
    '{32'h00045000, 2'd0, 8'h00, 1'b0, 2'd0, 32'h00000000, 3'b000, 1'b0, "R6"},
    '{32'hABCDA123, 2'd1, 8'h05, 1'b1, 2'd3, 32'h05555000, 3'b010, 1'b1, "R8"},
    '{32'hABCDA123, 2'd3, 8'h05, 1'b1, 2'd3, 32'h05555000, 3'b010, 1'b0, "R9"},
    '{32'hABCDA123, 2'd1, 8'h85, 1'b0, 2'd0, 32'h00000000, 3'b000, 1'b0, "R4"},
    '{32'h00013ABC, 2'd1, 8'h05, 1'b1, 2'd0, 32'h0ABCD000, 3'b110, 1'b1, "R7"}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] resp_word();
    return {24'h0, rsp_valid, rsp_hit, rsp_way, rsp_paddr, rsp_rd, rsp_wr, rsp_ex, rsp_allow};
  endfunction

  function automatic logic [63:0] exp_word(input logic v, input logic h, input logic [1:0] w,
                                           input logic [31:0] pa, input logic [2:0] pm,
                                           input logic al);
    return {24'h0, v, h, w, pa, pm, al};
  endfunction

  task automatic mwrite(input logic [5:0] a, input logic [31:0] t, input logic [23:0] d);
    @(negedge clk);
    mgmt_en = 1'b1; mgmt_we = 1'b1; mgmt_addr = a; mgmt_wtag = t; mgmt_wdata = d;
    @(negedge clk);
    mgmt_en = 1'b0; mgmt_we = 1'b0;
  endtask

  task automatic set_pid(input logic [7:0] p);
    @(negedge clk);
    ctl_wr_en = 1'b1;
    ctl_wr_data = 32'hA000_F00F | (32'(p) << 4);
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  // R10: the identifier is loaded; the request goes out in the following cycle
  task automatic lookup(input logic [31:0] va, input logic [1:0] k);
    req_valid = 1'b1; req_vaddr = va; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", {rsp_valid, rsp_hit, rsp_allow, rsp_paddr, mgmt_rtag, mgmt_rdata[0]},
          64'h0);

    for (int a = 0; a < 64; a++) mwrite(a[5:0], 32'hFFFFF000, 24'h0);
    mwrite(6'd3,  32'h00013405, 24'h60ABCD);  // way0 set3, pid5, rd+wr
    mwrite(6'd19, 32'h00013C09, 24'h111111);  // way1 set3, global, ex
    mwrite(6'd39, 32'h12347005, 24'h522222);  // way2 set7, valid clear, rd+ex
    mwrite(6'd55, 32'h12347405, 24'h733333);  // way3 set7, pid5, rwx
    mwrite(6'd18, 32'h00045C00, 24'h744444);  // way1 set2, VPN of set5
    mwrite(6'd58, 32'hABCDA405, 24'h205555);  // way3 set10, pid5, wr

    for (int i = 0; i < NV; i++) begin
      set_pid(VECS[i].pid);
      lookup(VECS[i].vaddr, VECS[i].kind);
      check(string'(VECS[i].req_tag[15:0]), resp_word(),
            exp_word(1'b1, VECS[i].hit, VECS[i].way, VECS[i].paddr, VECS[i].perm, VECS[i].allow));
    end

    // R10: a control write in the same cycle as a request leaves the old identifier in force
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = 32'h0000_0060;
    req_valid = 1'b1; req_vaddr = 32'h00013ABC; req_kind = 2'd0;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    check("R10", resp_word(), exp_word(1'b1, 1'b1, 2'd0, 32'h0ABCD000, 3'b110, 1'b1));
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", resp_word(), exp_word(1'b1, 1'b1, 2'd1, 32'h11111000, 3'b001, 1'b0));
    @(negedge clk);
    // R2: no request, no strobe
    check("R2", resp_word(), exp_word(1'b0, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0));

    // R11: management read-back
    mgmt_en = 1'b1; mgmt_we = 1'b0; mgmt_addr = 6'd55;
    @(negedge clk);
    mgmt_en = 1'b0;
    check("R11", {mgmt_rtag, 8'h0, mgmt_rdata}, {32'h12347405, 8'h0, 24'h733333});
    mgmt_en = 1'b1; mgmt_addr = 6'd3;
    @(negedge clk);
    mgmt_en = 1'b0;
    check("R11", {mgmt_rtag, 8'h0, mgmt_rdata}, {32'h00013405, 8'h0, 24'h60ABCD});

    // R6: a write into the correctly indexed set is found afterwards
    mwrite(6'd37, 32'h00045C00, 24'h466666);
    lookup(32'h00045000, 2'd0);
    check("R6", resp_word(), exp_word(1'b1, 1'b1, 2'd2, 32'h66666000, 3'b100, 1'b1));

    // R1: reset in the same cycle as a request wins
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b1; req_vaddr = 32'h00013ABC; req_kind = 2'd0;
    @(negedge clk);
    rst = 1'b0; req_valid = 1'b0;
    check("R1", resp_word(), exp_word(1'b0, 1'b0, 2'd0, 32'h0, 3'b000, 1'b0));

    // R1: the identifier is back to 0, so the pid5 entry in way0 no longer hits and global way1 wins
    lookup(32'h00013ABC, 2'd2);
    check("R1", resp_word(), exp_word(1'b1, 1'b1, 2'd1, 32'h11111000, 3'b001, 1'b1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule